// File: doc/BRIEF.md
# Branch and Move Condition Evaluator

This combinational unit decides whether a conditional branch, an integer conditional move or a floating-point conditional move takes effect. It reads three families of condition sources. The first is two integer flag sets (a narrow 32-bit set and a wide 64-bit set, each holding N, Z, V and C) with a select between them. The second is four 2-bit floating-point comparison fields with an index that picks one. The third is a 64-bit register value whose contents are tested directly.

A 2-bit mode input chooses the family, and a 4-bit condition selector chooses the test within it. A single output bit reports whether the chosen condition holds. Nothing is stored, so the answer follows the inputs in the same cycle. Fetch, prediction hints, annulling and the move datapath belong to the surrounding pipeline.

Top module: `cond_eval`

## Requirements
- R1: With mode 0 (integer flags; flag bits ordered N=bit 3, Z=bit 2, V=bit 1, C=bit 0), selector codes 0..3 and 8..11 give: 0 never (0), 1 equal Z, 2 less-or-equal Z|(N^V), 3 less N^V, 8 always (1), 9 not-equal !Z, 10 greater !(Z|(N^V)), 11 greater-or-equal !(N^V).
- R2: With mode 0, selector codes 4..7 and 12..15 give: 4 C|Z, 5 C, 6 N, 7 V, 12 !(C|Z), 13 !C, 14 !N, 15 !V.
- R3: In mode 0, `wide_sel`=0 evaluates the narrow flag input `icc` and `wide_sel`=1 evaluates the wide flag input `xcc`; the unselected set has no effect on `take`.
- R4: With mode 1, field k of `fcc_all` occupies bits [2k+1:2k]; `fcc_idx` picks the field, and a field value of 00 means equal (E), 01 less (L), 10 greater (G) and 11 unordered (U). The fields that are not picked have no effect.
- R5: With mode 1, the selector codes give: 0 never, 1 L|G|U, 2 L|G, 3 L|U, 4 L, 5 G|U, 6 G, 7 U, 8 always, 9 E, 10 E|U, 11 E|G, 12 E|G|U, 13 E|L, 14 E|L|U, 15 E|L|G.
- R6: With mode 2, where Z means every bit of `reg_val` is zero and N is bit 63, selector bits [2:0] give: 1 Z, 2 N|Z, 3 N, 5 !Z, 6 !(N|Z), 7 !N.
- R7: With mode 2, selector bits [2:0] equal to 0 or 4 give 0, and selector bit 3 has no effect.
- R8: Mode 3 is reserved and gives 0 for every selector and input value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 2 | Condition family: 0 integer flags, 1 floating-point field, 2 register contents, 3 reserved |
| cond | input | 4 | Test selector |
| wide_sel | input | 1 | Integer flag set select: 0 narrow, 1 wide |
| icc | input | 4 | Narrow integer flags {N,Z,V,C} |
| xcc | input | 4 | Wide integer flags {N,Z,V,C} |
| fcc_all | input | 8 | Four 2-bit floating-point comparison fields |
| fcc_idx | input | 2 | Index of the floating-point field to test |
| reg_val | input | 64 | Register value for content tests |
| take | output | 1 | Condition holds |

## Verification
The bench sweeps every selector over all sixteen flag values of the chosen set, while the unselected set takes all sixteen values too. A design that read the wrong set, or that swapped a signed test with its unsigned partner, would therefore disagree on some vector. In floating-point mode every selector meets every value of all four fields with each index. This exposes a mis-indexed field, a swapped encoding, or an unordered result that leaks into an ordered test. Register mode is driven with zero, one, the lone sign bit, all ones and the largest positive value. These catch a zero detector that checks only part of the word, or a sign taken from the wrong bit. Reserved register codes, the ignored selector bit 3 and the reserved mode must all give 0.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    typedef enum logic [1:0] {
        MODE_INT  = 2'd0,
        MODE_FP   = 2'd1,
        MODE_REG  = 2'd2,
        MODE_RSVD = 2'd3
    } eval_mode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } iflags_t;

    typedef enum logic [1:0] {
        FCMP_EQ = 2'd0,
        FCMP_LT = 2'd1,
        FCMP_GT = 2'd2,
        FCMP_UN = 2'd3
    } fcmp_e;

endpackage

// File: rtl/cond_int_eval.sv
module cond_int_eval
    import cond_eval_pkg::*;
(
    input  logic [3:0] code,
    input  logic       use_wide,
    input  logic [3:0] narrow_f,
    input  logic [3:0] wide_f,
    output logic       hit
);
    iflags_t   f;
    logic [7:0] neg_half;
    logic [7:0] pos_half;

    assign f = iflags_t'(use_wide ? wide_f : narrow_f);

    always_comb begin
        neg_half[0] = 1'b0;
        neg_half[1] = f.z;
        neg_half[2] = f.z | (f.n ^ f.v);
        neg_half[3] = f.n ^ f.v;
        neg_half[4] = f.c | f.z;
        neg_half[5] = f.c;
        neg_half[6] = f.n;
        neg_half[7] = f.v;
    end

    always_comb begin
        pos_half[0] = 1'b1;
        pos_half[1] = !f.z;
        pos_half[2] = !f.z & (f.n ~^ f.v);
        pos_half[3] = f.n ~^ f.v;
        pos_half[4] = !f.c & !f.z;
        pos_half[5] = !f.c;
        pos_half[6] = !f.n;
        pos_half[7] = !f.v;
    end

    assign hit = code[3] ? pos_half[code[2:0]] : neg_half[code[2:0]];

    // R1 / R2: each upper-half test is the exact inverse of its lower partner
    always_comb begin
        p_int_pairs_r1: assert ((pos_half ^ neg_half) == 8'hFF)
            else $error("integer test pair not complementary");
    end

endmodule

// File: rtl/cond_fp_eval.sv
module cond_fp_eval
    import cond_eval_pkg::*;
#(
    parameter int NUM_FCC = 4,
    localparam int IDX_W  = (NUM_FCC > 1) ? $clog2(NUM_FCC) : 1
) (
    input  logic [3:0]           code,
    input  logic [2*NUM_FCC-1:0] fields,
    input  logic [IDX_W-1:0]     idx,
    output logic                 hit
);
    logic [1:0] fld [NUM_FCC];
    fcmp_e      rel;
    logic       e, l, g, u;
    logic [7:0] lo_half;
    logic [7:0] hi_half;

    for (genvar k = 0; k < NUM_FCC; k++) begin : g_field
        assign fld[k] = fields[2*k +: 2];
    end

    assign rel = fcmp_e'(fld[idx]);
    assign e = (rel == FCMP_EQ);
    assign l = (rel == FCMP_LT);
    assign g = (rel == FCMP_GT);
    assign u = (rel == FCMP_UN);

    always_comb begin
        lo_half[0] = 1'b0;
        lo_half[1] = l | g | u;
        lo_half[2] = l | g;
        lo_half[3] = l | u;
        lo_half[4] = l;
        lo_half[5] = g | u;
        lo_half[6] = g;
        lo_half[7] = u;
        hi_half[0] = 1'b1;
        hi_half[1] = e;
        hi_half[2] = e | u;
        hi_half[3] = e | g;
        hi_half[4] = e | g | u;
        hi_half[5] = e | l;
        hi_half[6] = e | l | u;
        hi_half[7] = e | l | g;
    end

    assign hit = code[3] ? hi_half[code[2:0]] : lo_half[code[2:0]];

    // R5: the relation decode yields exactly one outcome, so the halves mirror
    always_comb begin
        p_fp_pairs_r5: assert ((hi_half ^ lo_half) == 8'hFF)
            else $error("floating-point test pair not complementary");
        p_fp_onehot_r4: assert ($onehot({e, l, g, u}))
            else $error("field decode not one-hot");
    end

endmodule

// File: rtl/cond_reg_eval.sv
module cond_reg_eval #(
    parameter int DATA_W = 64
) (
    input  logic [2:0]        code,
    input  logic [DATA_W-1:0] val,
    output logic              hit
);
    logic       is_zero;
    logic       is_neg;
    logic [7:0] tv;

    assign is_zero = (val == '0);
    assign is_neg  = val[DATA_W-1];

    always_comb begin
        tv[0] = 1'b0;
        tv[1] = is_zero;
        tv[2] = is_neg | is_zero;
        tv[3] = is_neg;
        tv[4] = 1'b0;
        tv[5] = !is_zero;
        tv[6] = !is_neg & !is_zero;
        tv[7] = !is_neg;
    end

    assign hit = tv[code];

    always_comb begin
        // R7: the two unused codes never report true
        p_reg_rsvd_r7: assert (!((code[1:0] == 2'b00) && hit))
            else $error("unused register code returned true");
        // R6: each test and its code-bit-2 partner disagree
        p_reg_pairs_r6: assert ((tv[7:5] ^ tv[3:1]) == 3'b111)
            else $error("register test pair not complementary");
    end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_eval_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int NUM_FCC = 4,
    localparam int IDX_W  = (NUM_FCC > 1) ? $clog2(NUM_FCC) : 1
) (
    input  logic [1:0]           mode,
    input  logic [3:0]           cond,
    input  logic                 wide_sel,
    input  logic [3:0]           icc,
    input  logic [3:0]           xcc,
    input  logic [2*NUM_FCC-1:0] fcc_all,
    input  logic [IDX_W-1:0]     fcc_idx,
    input  logic [DATA_W-1:0]    reg_val,
    output logic                 take
);
    eval_mode_e m;
    logic       int_hit;
    logic       fp_hit;
    logic       reg_hit;

    assign m = eval_mode_e'(mode);

    cond_int_eval u_int (
        .code     (cond),
        .use_wide (wide_sel),
        .narrow_f (icc),
        .wide_f   (xcc),
        .hit      (int_hit)
    );

    cond_fp_eval #(.NUM_FCC(NUM_FCC)) u_fp (
        .code   (cond),
        .fields (fcc_all),
        .idx    (fcc_idx),
        .hit    (fp_hit)
    );

    cond_reg_eval #(.DATA_W(DATA_W)) u_reg (
        .code (cond[2:0]),
        .val  (reg_val),
        .hit  (reg_hit)
    );

    always_comb begin
        unique case (m)
            MODE_INT:  take = int_hit;
            MODE_FP:   take = fp_hit;
            MODE_REG:  take = reg_hit;
            MODE_RSVD: take = 1'b0;
            default:   take = 1'b0;
        endcase
    end

    // R8: reserved mode never asserts the result, whatever the evaluators say
    always_comb begin
        p_rsvd_mode_r8: assert (!((mode == 2'd3) && take))
            else $error("reserved mode returned true");
    end

endmodule

// File: tb/cond_eval_tb.sv
module cond_eval_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  exp;
        string tag;
        int    md;
        int    cd;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = '0;
    logic [3:0]  cond = '0;
    logic        wide_sel = 1'b0;
    logic [3:0]  icc = '0;
    logic [3:0]  xcc = '0;
    logic [7:0]  fcc_all = '0;
    logic [1:0]  fcc_idx = '0;
    logic [63:0] reg_val = '0;
    logic        take;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;
    sb_item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_eval u_dut (
        .mode     (mode),
        .cond     (cond),
        .wide_sel (wide_sel),
        .icc      (icc),
        .xcc      (xcc),
        .fcc_all  (fcc_all),
        .fcc_idx  (fcc_idx),
        .reg_val  (reg_val),
        .take     (take)
    );

    function automatic logic ref_int(input logic [3:0] c, input logic [3:0] f);
        logic n, z, v, k;
        n = f[3]; z = f[2]; v = f[1]; k = f[0];
        case (c)
            4'd0:  return 1'b0;
            4'd1:  return z;
            4'd2:  return z | (n ^ v);
            4'd3:  return n ^ v;
            4'd4:  return k | z;
            4'd5:  return k;
            4'd6:  return n;
            4'd7:  return v;
            4'd8:  return 1'b1;
            4'd9:  return !z;
            4'd10: return !(z | (n ^ v));
            4'd11: return !(n ^ v);
            4'd12: return !(k | z);
            4'd13: return !k;
            4'd14: return !n;
            default: return !v;
        endcase
    endfunction

    function automatic logic ref_fp(input logic [3:0] c, input logic [1:0] r);
        logic e, l, g, u;
        e = (r == 2'b00); l = (r == 2'b01); g = (r == 2'b10); u = (r == 2'b11);
        case (c)
            4'd0:  return 1'b0;
            4'd1:  return l | g | u;
            4'd2:  return l | g;
            4'd3:  return l | u;
            4'd4:  return l;
            4'd5:  return g | u;
            4'd6:  return g;
            4'd7:  return u;
            4'd8:  return 1'b1;
            4'd9:  return e;
            4'd10: return e | u;
            4'd11: return e | g;
            4'd12: return e | g | u;
            4'd13: return e | l;
            4'd14: return e | l | u;
            default: return e | l | g;
        endcase
    endfunction

    function automatic logic ref_reg(input logic [2:0] c, input logic [63:0] x);
        logic z, n;
        z = (x == 64'd0); n = x[63];
        case (c)
            3'd1: return z;
            3'd2: return n | z;
            3'd3: return n;
            3'd5: return !z;
            3'd6: return !(n | z);
            3'd7: return !n;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push(input logic e, input string t);
        sb_item_t it;
        it.exp = e; it.tag = t; it.md = int'(mode); it.cd = int'(cond);
        sb.push_back(it);
    endtask

    task automatic step_drive(input logic [1:0] md, input logic [3:0] cd, input logic ws,
                              input logic [3:0] ic, input logic [3:0] xc,
                              input logic [7:0] fa, input logic [1:0] fi,
                              input logic [63:0] rv, input logic e, input string t);
        @(posedge clk);
        #1;
        mode = md; cond = cd; wide_sel = ws; icc = ic; xcc = xc;
        fcc_all = fa; fcc_idx = fi; reg_val = rv;
        push(e, t);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            sb_item_t it;
            it = sb.pop_front();
            compared++;
            if (take !== it.exp) begin
                mismatched++;
                $display("FAIL %s mode=%0d cond=%0d actual=%b expected=%b",
                         it.tag, it.md, it.cd, take, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [63:0] pats [10];
        pats[0] = 64'h0;
        pats[1] = 64'h1;
        pats[2] = 64'h8000_0000_0000_0000;
        pats[3] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[4] = 64'h7FFF_FFFF_FFFF_FFFF;
        pats[5] = 64'h0000_0001_0000_0000;
        pats[6] = 64'h8000_0000_0000_0001;
        pats[7] = 64'h0000_0000_8000_0000;
        pats[8] = 64'hFFFF_0000_0000_0000;
        pats[9] = 64'h4000_0000_0000_0000;

        // reset-time state: all inputs zero -> integer never -> 0 (R1)
        repeat (2) @(posedge clk);
        #1;
        push(1'b0, "R1");
        @(posedge clk);
        rst_n = 1'b1;

        // integer family, narrow and wide sets, other set swept too (R1, R2, R3)
        for (int ws = 0; ws < 2; ws++)
            for (int c = 0; c < 16; c++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++) begin
                        logic ev;
                        string t;
                        ev = ref_int(4'(c), (ws == 1) ? 4'(b) : 4'(a));
                        if (ws == 1) t = "R3";
                        else if ((c % 8) < 4) t = "R1";
                        else t = "R2";
                        step_drive(2'd0, 4'(c), 1'(ws), 4'(a), 4'(b), 8'h00, 2'd0,
                                   64'h0, ev, t);
                    end

        // floating-point family, every field value under every index (R4, R5)
        for (int i = 0; i < 4; i++)
            for (int c = 0; c < 16; c++)
                for (int fa = 0; fa < 256; fa++) begin
                    logic [7:0] fv;
                    logic [1:0] r;
                    fv = 8'(fa);
                    r = fv[2*i +: 2];
                    step_drive(2'd1, 4'(c), 1'b0, 4'hF, 4'hF, fv, 2'(i), 64'h0,
                               ref_fp(4'(c), r), (i == 0) ? "R5" : "R4");
                end

        // register family incl. unused codes and ignored selector bit 3 (R6, R7)
        for (int c = 0; c < 16; c++)
            for (int p = 0; p < 10; p++) begin
                logic [3:0] cv;
                string t;
                cv = 4'(c);
                t = (cv[3] || cv[1:0] == 2'b00) ? "R7" : "R6";
                step_drive(2'd2, cv, 1'b0, 4'hF, 4'hF, 8'hFF, 2'd3, pats[p],
                           ref_reg(cv[2:0], pats[p]), t);
            end

        // reserved mode (R8)
        for (int c = 0; c < 16; c++)
            for (int p = 0; p < 4; p++)
                step_drive(2'd3, 4'(c), 1'(p), 4'(p * 5), 4'(15 - p), 8'(p * 85),
                           2'(p), pats[p], 1'b0, "R8");

        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule